// File: doc/BRIEF.md
# Mode-Gated Bus-Control Pin Assignment

This block owns three shared port pins that can serve either as general-purpose I/O or as bus-control outputs. The three bus functions are the bus clock output, the low-byte write strobe and the read/write strobe. A 16-bit configuration word holds the pin-assignment controls in its upper byte and a clock-stretch control in its lower byte. Software writes the word through a simple write port with byte enables, and can read it back at any time.

Write protection depends on the operating mode, which the block takes as an input. In normal modes each byte of the word accepts exactly one write after reset. In special modes the first write to a byte is discarded and every later write lands. Each pin's bus function is further qualified by the current mode. A pin in bus function always drives its output, whatever its direction bit says. A pin in GPIO function follows the GPIO data and direction inputs.

In special expanded mode, with tagging armed, the block also watches the low-strobe pin. It raises a one-cycle tag flag when it sees the pin low at a falling edge of the bus clock.

Top module: `buspin_cfg`

## Requirements
- R1: `rd_data_o` is combinational and readable in every mode. It equals `{5'b0, rw_en, lstr_en, clk_off, 7'b0, stretch}`: upper byte bit 0 is clk_off, bit 1 is lstr_en, bit 2 is rw_en, and lower byte bit 0 is stretch. All other bits read 0.
- R2: The mode is encoded as 0 = normal single-chip, 1 = normal expanded narrow, 2 = normal expanded wide, 3 = special expanded and 4 to 7 = special single-chip. In modes 0 to 2, the first write to a byte after reset is stored and every later write to that byte is ignored.
- R3: In modes 3 to 7, the first write to a byte after reset is ignored and every later write to that byte is stored.
- R4: Each byte is enabled by its own bit: `wr_be_i[1]` for the upper byte and `wr_be_i[0]` for the lower byte. Each byte tracks its own first write. A write with both enables set updates both bytes in the same cycle. A write to one byte does not use up the other byte's first write.
- R5: After reset all stored bits are 0, so `rd_data_o` reads 0. The strobe pins start as GPIO, and the clock pin starts in bus function.
- R6: Pin 0 carries `bclk_i` with its output enable at 1 when clk_off = 0. In single-chip modes (0 and 4 to 7), stretch must also be 0. Otherwise pin 0 is GPIO.
- R7: Pin 1 carries `lstrb_bus_i` with its output enable at 1 only when lstr_en = 1 and the mode is 2 or 3. Otherwise pin 1 is GPIO.
- R8: Pin 2 carries `rw_bus_i` with its output enable at 1 only when rw_en = 1 and the mode is 1, 2 or 3. Otherwise pin 2 is GPIO.
- R9: A GPIO pin drives `gpio_dout_i` with output enable `gpio_dir_i`. It reads back `gpio_dout_i` when its direction bit is 1, and the live `pin_in_i` when it is 0. A pin in bus function has output enable 1 regardless of its direction bit, and reads back the live `pin_in_i`.
- R10: `tag_lo_o` goes high for exactly one cycle after a clock edge at which all of the following hold: mode is 3, lstr_en = 1, `tag_en_i` = 1, `bclk_i` is 0 while it was 1 at the previous edge, and `pin_in_i[1]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Operating mode |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_be_i | input | 2 | Byte enables (1 = upper, 0 = lower) |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Configuration readback |
| bclk_i | input | 1 | Bus clock from the bus controller |
| lstrb_bus_i | input | 1 | Low-byte strobe from the bus controller |
| rw_bus_i | input | 1 | Read/write strobe from the bus controller |
| tag_en_i | input | 1 | Instruction tagging armed |
| gpio_dout_i | input | 3 | GPIO data register |
| gpio_dir_i | input | 3 | GPIO direction register (1 = output) |
| pin_in_i | input | 3 | Live pad levels |
| pin_out_o | output | 3 | Pad output values |
| pin_oe_o | output | 3 | Pad output enables |
| gpio_rd_o | output | 3 | GPIO data readback |
| tag_lo_o | output | 1 | Low-byte instruction tag pulse |

## Verification
The bench goes after the first write in each mode family. A design that treated special modes as normal would keep the first value written and then lock the byte. A design that shared one tracking flag across both bytes would silently drop a write to the second byte. The bench also sets enables in the modes where they must have no effect: narrow mode and single-chip for the low strobe, and single-chip for the read/write strobe. An ungated mux would there hand the pin to the bus and force its output enable, ignoring the direction bit. Tag pulses are provoked in special expanded mode and attempted in normal wide mode, where a design that skipped the mode qualifier would emit a spurious tag.

// File: rtl/buspin_pkg.sv
package buspin_pkg;

   typedef enum logic [2:0] {
      MD_SC_NORM    = 3'd0,
      MD_EXP_NARROW = 3'd1,
      MD_EXP_WIDE   = 3'd2,
      MD_EXP_SPEC   = 3'd3,
      MD_SC_SPEC    = 3'd4
   } op_mode_e;

   function automatic logic is_special(input logic [2:0] m);
      return (m >= 3'd3);
   endfunction

   function automatic logic is_single(input logic [2:0] m);
      return (m == MD_SC_NORM) || (m >= MD_SC_SPEC);
   endfunction

   function automatic logic lstr_allowed(input logic [2:0] m);
      return (m == MD_EXP_WIDE) || (m == MD_EXP_SPEC);
   endfunction

   function automatic logic rw_allowed(input logic [2:0] m);
      return !is_single(m);
   endfunction

endpackage

// File: rtl/buspin_wprot.sv
module buspin_wprot #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         special_i,
   input  logic         wr_i,
   input  logic [W-1:0] wd_i,
   output logic [W-1:0] q_o
);
   generate
      if (W < 1) begin : g_bad_w
         $error("buspin_wprot: W must be positive");
      end
   endgenerate

   logic         seen_q;
   logic [W-1:0] val_q;
   logic         take;

   // normal modes take the first write; special modes take every later one
   assign take = special_i ? seen_q : !seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= 1'b0;
         val_q  <= '0;
      end else if (wr_i) begin
         seen_q <= 1'b1;
         if (take) val_q <= wd_i;
      end
   end

   assign q_o = val_q;

   // R2
   wonce_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && seen_q && !special_i) |=> $stable(val_q));

   // R3
   first_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !seen_q && special_i) |=> $stable(val_q));

   // R3
   later_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && seen_q && special_i) |=> (val_q == $past(wd_i)));

endmodule

// File: rtl/buspin_padmux.sv
module buspin_padmux #(
   parameter int NP = 3
) (
   input  logic [NP-1:0] fn_bus_i,
   input  logic [NP-1:0] bus_out_i,
   input  logic [NP-1:0] gp_dout_i,
   input  logic [NP-1:0] gp_dir_i,
   input  logic [NP-1:0] pin_in_i,
   output logic [NP-1:0] pin_out_o,
   output logic [NP-1:0] pin_oe_o,
   output logic [NP-1:0] gp_rd_o
);
   generate
      if (NP < 1) begin : g_bad_np
         $error("buspin_padmux: NP must be positive");
      end
      for (genvar i = 0; i < NP; i++) begin : g_pin
         always_comb begin
            if (fn_bus_i[i]) begin
               pin_out_o[i] = bus_out_i[i];
               pin_oe_o[i]  = 1'b1;
               gp_rd_o[i]   = pin_in_i[i];
            end else begin
               pin_out_o[i] = gp_dout_i[i];
               pin_oe_o[i]  = gp_dir_i[i];
               gp_rd_o[i]   = gp_dir_i[i] ? gp_dout_i[i] : pin_in_i[i];
            end
         end
      end
   endgenerate

   // R9
   padmux_rd_chk: assert final ((pin_oe_o & ~gp_dir_i & ~fn_bus_i) == '0);

endmodule

// File: rtl/buspin_tagdet.sv
module buspin_tagdet (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic bclk_i,
   input  logic strobe_pin_i,
   output logic tag_o
);
   logic bclk_q;
   logic tag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_q <= 1'b0;
         tag_q  <= 1'b0;
      end else begin
         bclk_q <= bclk_i;
         tag_q  <= arm_i && bclk_q && !bclk_i && !strobe_pin_i;
      end
   end

   assign tag_o = tag_q;

   // R10
   tag_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tag_o |=> !tag_o);

   // R10
   tag_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tag_o |-> ($past(arm_i) && !$past(strobe_pin_i)));

endmodule

// File: rtl/buspin_cfg.sv
module buspin_cfg #(
   parameter int BYTE_W   = 8,
   parameter int NPINS    = 3,
   parameter int CLK_BIT  = 0,
   parameter int LSTR_BIT = 1,
   parameter int RW_BIT   = 2,
   parameter int STR_BIT  = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2:0]          mode_i,
   input  logic                wr_en_i,
   input  logic [1:0]          wr_be_i,
   input  logic [2*BYTE_W-1:0] wr_data_i,
   output logic [2*BYTE_W-1:0] rd_data_o,
   input  logic                bclk_i,
   input  logic                lstrb_bus_i,
   input  logic                rw_bus_i,
   input  logic                tag_en_i,
   input  logic [NPINS-1:0]    gpio_dout_i,
   input  logic [NPINS-1:0]    gpio_dir_i,
   input  logic [NPINS-1:0]    pin_in_i,
   output logic [NPINS-1:0]    pin_out_o,
   output logic [NPINS-1:0]    pin_oe_o,
   output logic [NPINS-1:0]    gpio_rd_o,
   output logic                tag_lo_o
);
   import buspin_pkg::*;

   localparam int DATA_W = 2 * BYTE_W;
   localparam logic [BYTE_W-1:0] PMASK =
      (BYTE_W'(1) << CLK_BIT) | (BYTE_W'(1) << LSTR_BIT) | (BYTE_W'(1) << RW_BIT);
   localparam logic [BYTE_W-1:0] MMASK = BYTE_W'(1) << STR_BIT;

   generate
      if (NPINS != 3) begin : g_bad_pins
         $error("buspin_cfg: exactly three shared pins are supported");
      end
      if (CLK_BIT >= BYTE_W || LSTR_BIT >= BYTE_W || RW_BIT >= BYTE_W
          || STR_BIT >= BYTE_W) begin : g_bad_pos
         $error("buspin_cfg: control bit outside the byte");
      end
      if (CLK_BIT == LSTR_BIT || CLK_BIT == RW_BIT || LSTR_BIT == RW_BIT) begin : g_bad_dup
         $error("buspin_cfg: control bits overlap");
      end
   endgenerate

   logic              special;
   logic [BYTE_W-1:0] pin_q;
   logic [BYTE_W-1:0] mod_q;
   logic              clk_off, lstr_en, rw_en, stretch;
   logic [NPINS-1:0]  fn_bus;
   logic [NPINS-1:0]  bus_out;
   logic              tag_arm;

   assign special = is_special(mode_i);

   buspin_wprot #(.W(BYTE_W)) u_pinbyte (
      .clk       (clk),
      .rst_n     (rst_n),
      .special_i (special),
      .wr_i      (wr_en_i && wr_be_i[1]),
      .wd_i      (wr_data_i[DATA_W-1:BYTE_W]),
      .q_o       (pin_q)
   );

   buspin_wprot #(.W(BYTE_W)) u_modbyte (
      .clk       (clk),
      .rst_n     (rst_n),
      .special_i (special),
      .wr_i      (wr_en_i && wr_be_i[0]),
      .wd_i      (wr_data_i[BYTE_W-1:0]),
      .q_o       (mod_q)
   );

   assign clk_off = pin_q[CLK_BIT];
   assign lstr_en = pin_q[LSTR_BIT];
   assign rw_en   = pin_q[RW_BIT];
   assign stretch = mod_q[STR_BIT];

   assign rd_data_o = {pin_q & PMASK, mod_q & MMASK};

   always_comb begin
      fn_bus[0] = !clk_off && (!is_single(mode_i) || !stretch);
      fn_bus[1] = lstr_en && lstr_allowed(mode_i);
      fn_bus[2] = rw_en && rw_allowed(mode_i);
   end

   assign bus_out = {rw_bus_i, lstrb_bus_i, bclk_i};

   buspin_padmux #(.NP(NPINS)) u_mux (
      .fn_bus_i  (fn_bus),
      .bus_out_i (bus_out),
      .gp_dout_i (gpio_dout_i),
      .gp_dir_i  (gpio_dir_i),
      .pin_in_i  (pin_in_i),
      .pin_out_o (pin_out_o),
      .pin_oe_o  (pin_oe_o),
      .gp_rd_o   (gpio_rd_o)
   );

   assign tag_arm = (mode_i == MD_EXP_SPEC) && lstr_en && tag_en_i;

   buspin_tagdet u_tag (
      .clk          (clk),
      .rst_n        (rst_n),
      .arm_i        (tag_arm),
      .bclk_i       (bclk_i),
      .strobe_pin_i (pin_in_i[1]),
      .tag_o        (tag_lo_o)
   );

   // R7 R8
   sc_strobe_gpio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_single(mode_i) |-> (pin_oe_o[2:1] == gpio_dir_i[2:1]));

   // R6
   sc_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_single(mode_i) && rd_data_o[STR_BIT]) |-> (pin_oe_o[0] == gpio_dir_i[0]));

   // R7
   narrow_lstr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MD_EXP_NARROW) |-> (pin_oe_o[1] == gpio_dir_i[1]));

   // R10
   tag_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tag_lo_o |-> ($past(mode_i) == MD_EXP_SPEC));

endmodule

// File: tb/sim_buspin_cfg.sv
module sim_buspin_cfg;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  mode_i = 3'd2;
   logic        wr_en_i = 1'b0;
   logic [1:0]  wr_be_i = 2'b00;
   logic [15:0] wr_data_i = 16'h0;
   logic [15:0] rd_data_o;
   logic        bclk_i = 1'b0, lstrb_bus_i = 1'b0, rw_bus_i = 1'b0, tag_en_i = 1'b0;
   logic [2:0]  gpio_dout_i = 3'b0, gpio_dir_i = 3'b0, pin_in_i = 3'b111;
   logic [2:0]  pin_out_o, pin_oe_o, gpio_rd_o;
   logic        tag_lo_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   // reference state
   bit m_off, m_lstr, m_rw, m_str, m_seen_hi, m_seen_lo, m_bprev, m_tag;

   always #5 clk = ~clk;

   buspin_cfg u0 (.*);

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit m_special(input logic [2:0] m);
      return m >= 3;
   endfunction
   function automatic bit m_single(input logic [2:0] m);
      return m == 0 || m >= 4;
   endfunction

   task automatic model_update();
      bit take;
      if (!rst_n) begin
         {m_off, m_lstr, m_rw, m_str, m_seen_hi, m_seen_lo, m_bprev, m_tag} = '0;
         return;
      end
      m_tag = (mode_i == 3) && m_lstr && tag_en_i && m_bprev && !bclk_i && !pin_in_i[1];
      m_bprev = bclk_i;
      if (wr_en_i && wr_be_i[1]) begin
         take = m_special(mode_i) ? m_seen_hi : !m_seen_hi;
         if (take) begin
            m_off = wr_data_i[8]; m_lstr = wr_data_i[9]; m_rw = wr_data_i[10];
         end
         m_seen_hi = 1;
      end
      if (wr_en_i && wr_be_i[0]) begin
         take = m_special(mode_i) ? m_seen_lo : !m_seen_lo;
         if (take) m_str = wr_data_i[0];
         m_seen_lo = 1;
      end
   endtask

   task automatic compare();
      logic [2:0] fn, bo, e_out, e_oe, e_rd;
      fn[0] = !m_off && (!m_single(mode_i) || !m_str);
      fn[1] = m_lstr && (mode_i == 2 || mode_i == 3);
      fn[2] = m_rw && !m_single(mode_i);
      bo = {rw_bus_i, lstrb_bus_i, bclk_i};
      for (int i = 0; i < 3; i++) begin
         e_out[i] = fn[i] ? bo[i] : gpio_dout_i[i];
         e_oe[i]  = fn[i] ? 1'b1 : gpio_dir_i[i];
         e_rd[i]  = fn[i] ? pin_in_i[i] : (gpio_dir_i[i] ? gpio_dout_i[i] : pin_in_i[i]);
      end
      chk("R1 R2 R3 R4 readback", rd_data_o, {5'b0, m_rw, m_lstr, m_off, 7'b0, m_str});
      chk("R6 R7 R8 pin_out", {13'b0, pin_out_o}, {13'b0, e_out});
      chk("R6 R7 R8 R9 pin_oe", {13'b0, pin_oe_o}, {13'b0, e_oe});
      chk("R9 gpio_rd", {13'b0, gpio_rd_o}, {13'b0, e_rd});
      chk("R10 tag", {15'b0, tag_lo_o}, {15'b0, m_tag});
   endtask

   task automatic cyc();
      @(posedge clk);
      model_update();
      @(negedge clk);
      compare();
      gpio_dout_i = 3'($urandom);
      gpio_dir_i  = 3'($urandom);
      lstrb_bus_i = 1'($urandom);
      rw_bus_i    = 1'($urandom);
   endtask

   task automatic do_reset(input logic [2:0] m);
      rst_n = 1'b0; mode_i = m; wr_en_i = 0; tag_en_i = 0; bclk_i = 0;
      repeat (2) cyc();
      rst_n = 1'b1;
      cyc();
   endtask

   task automatic wr(input logic [1:0] be, input logic [15:0] d);
      wr_en_i = 1; wr_be_i = be; wr_data_i = d;
      cyc();
      wr_en_i = 0; wr_be_i = 0;
   endtask

   initial begin
      // normal expanded wide
      do_reset(3'd2);
      chk("R5 reset readback", rd_data_o, 16'h0000);
      gpio_dir_i = 3'b000; bclk_i = 1; cyc();
      chk("R5 R6 clock pin driven", {15'b0, pin_oe_o[0]}, 16'h1);
      chk("R6 clock routed", {15'b0, pin_out_o[0]}, 16'h1);
      wr(2'b11, 16'h0601);
      chk("R2 R4 first write both bytes", rd_data_o, 16'h0601);
      wr(2'b11, 16'h0100);
      chk("R2 later write ignored", rd_data_o, 16'h0601);
      gpio_dir_i = 3'b000; cyc();
      chk("R7 R8 R9 strobes forced out", {13'b0, pin_oe_o}, 16'h7);
      tag_en_i = 1; bclk_i = 1; cyc();
      bclk_i = 0; pin_in_i = 3'b101; cyc();
      chk("R10 no tag in normal wide", {15'b0, tag_lo_o}, 16'h0);
      pin_in_i = 3'b111;

      // normal wide, clock disabled
      do_reset(3'd2);
      wr(2'b10, 16'h0100);
      gpio_dir_i = 3'b000; cyc();
      chk("R6 clock disabled gives GPIO", {15'b0, pin_oe_o[0]}, 16'h0);

      // special expanded
      do_reset(3'd3);
      wr(2'b11, 16'h0206);
      chk("R3 first write ignored", rd_data_o, 16'h0000);
      wr(2'b10, 16'h0200);
      chk("R3 second write taken", rd_data_o, 16'h0200);
      wr(2'b10, 16'h0600);
      chk("R3 third write taken", rd_data_o, 16'h0600);
      tag_en_i = 1; bclk_i = 1; pin_in_i = 3'b101; cyc();
      bclk_i = 0; cyc();
      chk("R10 tag after falling edge", {15'b0, tag_lo_o}, 16'h1);
      cyc();
      chk("R10 tag one cycle", {15'b0, tag_lo_o}, 16'h0);
      bclk_i = 1; pin_in_i = 3'b111; cyc();
      bclk_i = 0; cyc();
      chk("R10 no tag with strobe high", {15'b0, tag_lo_o}, 16'h0);
      tag_en_i = 0;

      // normal single-chip
      do_reset(3'd0);
      gpio_dir_i = 3'b000; cyc();
      chk("R6 single-chip clock out", {15'b0, pin_oe_o[0]}, 16'h1);
      wr(2'b01, 16'h0001);
      gpio_dir_i = 3'b000; cyc();
      chk("R6 stretch blocks clock", {15'b0, pin_oe_o[0]}, 16'h0);
      wr(2'b10, 16'h0600);
      chk("R4 separate byte tracking", rd_data_o, 16'h0601);
      gpio_dir_i = 3'b000; cyc();
      chk("R7 R8 no effect single-chip", {13'b0, pin_oe_o}, 16'h0);

      // normal expanded narrow
      do_reset(3'd1);
      wr(2'b10, 16'h0600);
      gpio_dir_i = 3'b000; cyc();
      chk("R7 narrow keeps low strobe GPIO", {15'b0, pin_oe_o[1]}, 16'h0);
      chk("R8 narrow read/write bus", {15'b0, pin_oe_o[2]}, 16'h1);

      // special single-chip
      do_reset(3'd4);
      wr(2'b01, 16'h0001);
      chk("R3 special single first ignored", rd_data_o, 16'h0000);
      wr(2'b01, 16'h0001);
      gpio_dir_i = 3'b000; cyc();
      chk("R3 R6 stretch then GPIO clock", {15'b0, pin_oe_o[0]}, 16'h0);

      repeat (20) cyc();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule